// File: doc/BRIEF.md
# Inverted Page Table Translator

This block turns a translation request made of a process identifier, a virtual page number and a page offset into a physical address. Its table is indexed by physical frame: there is exactly one entry per frame, and all processes share that one table. An entry records which process and which virtual page currently occupy its frame, along with a valid bit. Because the table has no index by virtual page, the frame number is not stored anywhere. It is the position of the matching entry, and the block finds that position by stepping through the table one entry per cycle.

A request is accepted with a valid/ready handshake. The block then scans from entry 0 upward and stops at the first entry that is valid and matches both the process identifier and the page number. It returns that entry's index joined to the request offset. If the last entry is passed without a match, it returns a page fault instead. Only one request is outstanding at a time. Entries are loaded through a separate write port. That port is closed from the moment a request is accepted until its response has been taken, so the table cannot change under a running scan.

Top module: `ipt_xlate`

## Requirements
- R1: After reset, req_ready and wr_ready are 1, rsp_valid is 0 and every entry is invalid, so any request faults.
- R2: An entry hits only when its valid bit is 1, its stored process identifier equals req_pid and its stored page number equals req_vpn. A match on only one field, or a match on an invalid entry, does not hit.
- R3: On a hit at entry k, rsp_fault is 0 and rsp_paddr equals k in bits 19:12 with the request offset in bits 11:0.
- R4: When several valid entries match, the lowest index is reported.
- R5: With acceptance at clock edge E0, rsp_valid rises at edge E0+k+1 for a hit at entry k. On a fault it rises at edge E0+256.
- R6: When no entry hits, rsp_fault is 1 and rsp_paddr is 0.
- R7: While rsp_valid is 1 and rsp_ready is 0, rsp_valid, rsp_fault and rsp_paddr hold their values. The response is retired on the edge where rsp_ready is 1.
- R8: req_ready is 0 from the acceptance edge until the edge that retires the response. Only one request is outstanding.
- R9: wr_ready is 0 during a scan and while a response is pending. A write takes effect only on an edge where wr_en and wr_ready are both 1. A held write lands once the response is retired. A write accepted on the same edge as a request is visible to that request's scan.
- R10: Writing an entry with wr_live = 0 removes its mapping, so a later request for that process and page faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_pid | input | 8 | Requesting process identifier |
| req_vpn | input | 20 | Virtual page number |
| req_ofs | input | 12 | Offset within the page |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_fault | output | 1 | 1 when no entry matched |
| rsp_paddr | output | 20 | Frame index joined to offset (0 on fault) |
| wr_en | input | 1 | Table write request |
| wr_ready | output | 1 | Table write can be accepted |
| wr_idx | input | 8 | Frame entry to write |
| wr_live | input | 1 | Valid bit to store |
| wr_pid | input | 8 | Process identifier to store |
| wr_vpn | input | 20 | Page number to store |

## Verification
The assertions assume that the request fields stay stable while req_valid is 1. They also assume that the consumer eventually raises rsp_ready, and that wr_en is only a request, which the block may hold off. The bench changes request fields only on falling edges and only while the block is idle. It keeps rsp_ready low for a few cycles to exercise the hold rule and then always retires the response. It drives the write port while a scan is running to show that the write is held back until the response has been taken.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_RESP = 2'd2
  } scan_state_e;
endpackage

// File: rtl/ipt_table.sv
module ipt_table #(
  parameter int FRAMES = 256,
  parameter int PID_W  = 8,
  parameter int VPN_W  = 20,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_commit,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_live,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_live,
  output logic [PID_W-1:0] rd_pid,
  output logic [VPN_W-1:0] rd_vpn
);
  logic [FRAMES-1:0] live_q;
  logic [PID_W-1:0]  pid_q [FRAMES];
  logic [VPN_W-1:0]  vpn_q [FRAMES];

  // valid bits are the only reset state; tags are don't-care while invalid
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (wr_commit) begin
      live_q[wr_idx] <= wr_live;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_commit) begin
      pid_q[wr_idx] <= wr_pid;
      vpn_q[wr_idx] <= wr_vpn;
    end
  end

  assign rd_live = live_q[rd_idx];
  assign rd_pid  = pid_q[rd_idx];
  assign rd_vpn  = vpn_q[rd_idx];

  // R9 / R10: an accepted write lands in the addressed entry
  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> (live_q[$past(wr_idx)] == $past(wr_live)));
endmodule

// File: rtl/ipt_scan.sv
module ipt_scan
  import ipt_pkg::*;
#(
  parameter int FRAMES = 256,
  parameter int PID_W  = 8,
  parameter int VPN_W  = 20,
  parameter int OFS_W  = 12,
  localparam int IDX_W = $clog2(FRAMES),
  localparam int PA_W  = IDX_W + OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [PID_W-1:0] req_pid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [OFS_W-1:0] req_ofs,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             rd_live,
  input  logic [PID_W-1:0] rd_pid,
  input  logic [VPN_W-1:0] rd_vpn,
  output logic             scan_idle,
  output logic             hit_now,
  output logic             miss_last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAMES - 1);

  function automatic logic entry_hits(input logic live,
                                      input logic [PID_W-1:0] e_pid,
                                      input logic [VPN_W-1:0] e_vpn,
                                      input logic [PID_W-1:0] k_pid,
                                      input logic [VPN_W-1:0] k_vpn);
    return live && (e_pid == k_pid) && (e_vpn == k_vpn);
  endfunction

  function automatic logic [PA_W-1:0] join_paddr(input logic [IDX_W-1:0] frame,
                                                 input logic [OFS_W-1:0] ofs);
    return {frame, ofs};
  endfunction

  scan_state_e      state_q;
  logic [IDX_W-1:0] idx_q;
  logic [PID_W-1:0] key_pid_q;
  logic [VPN_W-1:0] key_vpn_q;
  logic [OFS_W-1:0] key_ofs_q;
  logic [PA_W-1:0]  paddr_q;
  logic             fault_q;
  logic             accept;

  assign req_ready = (state_q == ST_IDLE);
  assign scan_idle = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_idx    = idx_q;
  assign hit_now   = (state_q == ST_SCAN) &&
                     entry_hits(rd_live, rd_pid, rd_vpn, key_pid_q, key_vpn_q);
  assign miss_last = (state_q == ST_SCAN) && !hit_now && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      key_pid_q <= '0;
      key_vpn_q <= '0;
      key_ofs_q <= '0;
      paddr_q   <= '0;
      fault_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            key_pid_q <= req_pid;
            key_vpn_q <= req_vpn;
            key_ofs_q <= req_ofs;
            idx_q     <= '0;
            state_q   <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (hit_now) begin
            paddr_q <= join_paddr(idx_q, key_ofs_q);
            fault_q <= 1'b0;
            state_q <= ST_RESP;
          end else if (miss_last) begin
            paddr_q <= '0;
            fault_q <= 1'b1;
            state_q <= ST_RESP;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_fault = fault_q;
  assign rsp_paddr = paddr_q;

  // R3: the reported frame is the entry index where the hit was seen
  p_frame_from_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_now |=> (rsp_valid && !rsp_fault && rsp_paddr[PA_W-1:OFS_W] == $past(idx_q)));

  // R5: a scan without a hit advances exactly one entry per cycle
  p_scan_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN && !hit_now && !miss_last) |=>
      (state_q == ST_SCAN && idx_q == IDX_W'($past(idx_q) + 1'b1)));

  // R6: a fault carries an all-zero address
  p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

  // R7: a stalled response holds still
  p_resp_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  // R8: one request in flight; acceptance closes the request port
  p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
endmodule

// File: rtl/ipt_xlate.sv
module ipt_xlate #(
  parameter int FRAMES = 256,
  parameter int PID_W  = 8,
  parameter int VPN_W  = 20,
  parameter int OFS_W  = 12,
  localparam int IDX_W = $clog2(FRAMES),
  localparam int PA_W  = IDX_W + OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [PID_W-1:0] req_pid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [OFS_W-1:0] req_ofs,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  input  logic             wr_en,
  output logic             wr_ready,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_live,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [VPN_W-1:0] wr_vpn
);
  logic [IDX_W-1:0] rd_idx;
  logic             rd_live;
  logic [PID_W-1:0] rd_pid;
  logic [VPN_W-1:0] rd_vpn;
  logic             scan_idle;
  logic             hit_now;
  logic             miss_last;
  logic             wr_commit;

  assign wr_ready  = scan_idle;
  assign wr_commit = wr_en && wr_ready;

  ipt_table #(.FRAMES(FRAMES), .PID_W(PID_W), .VPN_W(VPN_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_commit(wr_commit), .wr_idx(wr_idx), .wr_live(wr_live),
    .wr_pid(wr_pid), .wr_vpn(wr_vpn),
    .rd_idx(rd_idx), .rd_live(rd_live), .rd_pid(rd_pid), .rd_vpn(rd_vpn)
  );

  ipt_scan #(.FRAMES(FRAMES), .PID_W(PID_W), .VPN_W(VPN_W), .OFS_W(OFS_W)) u_scan (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_pid(req_pid), .req_vpn(req_vpn), .req_ofs(req_ofs),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .rd_idx(rd_idx), .rd_live(rd_live), .rd_pid(rd_pid), .rd_vpn(rd_vpn),
    .scan_idle(scan_idle), .hit_now(hit_now), .miss_last(miss_last)
  );

  // R9: the write port stays shut while a response waits
  p_write_shut_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !wr_ready);

  // R9: a write never coincides with a hit or a fault decision
  p_no_write_mid_scan_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_now || miss_last) |-> !wr_commit);
endmodule

// File: tb/ipt_xlate_bench.sv
module ipt_xlate_bench;
  localparam int FRAMES = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_pid = '0;
  logic [19:0] req_vpn = '0;
  logic [11:0] req_ofs = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_fault;
  logic [19:0] rsp_paddr;
  logic        wr_en = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_idx = '0;
  logic        wr_live = 1'b0;
  logic [7:0]  wr_pid = '0;
  logic [19:0] wr_vpn = '0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  ipt_xlate u_ipt_xlate (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_pid(req_pid), .req_vpn(req_vpn), .req_ofs(req_ofs),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .wr_en(wr_en), .wr_ready(wr_ready), .wr_idx(wr_idx),
    .wr_live(wr_live), .wr_pid(wr_pid), .wr_vpn(wr_vpn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  task automatic put_entry(input int idx, input logic live, input logic [7:0] pid,
                           input logic [19:0] vpn);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_en = 1'b1; wr_idx = idx[7:0]; wr_live = live; wr_pid = pid; wr_vpn = vpn;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // issue one request, measure edges to response, check everything, retire it
  task automatic xlate(input string tag, input logic [7:0] pid, input logic [19:0] vpn,
                       input logic [11:0] ofs, input logic exp_fault,
                       input int exp_frame, input bit same_cycle_write);
    int n;
    logic [19:0] exp_pa;
    logic [19:0] pa0;
    if (!same_cycle_write) @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_pid = pid; req_vpn = vpn; req_ofs = ofs;
    @(posedge clk);
    #1 req_valid = 1'b0; wr_en = 1'b0;
    n = 0;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (rsp_valid || n > FRAMES + 8) break;
    end
    exp_pa = exp_fault ? 20'd0 : {exp_frame[7:0], ofs};
    check({tag, " R5 latency"}, n, exp_fault ? FRAMES : exp_frame + 1);
    check({tag, " R6 fault flag"}, {31'd0, rsp_fault}, {31'd0, exp_fault});
    check({tag, " R3 paddr"}, {12'd0, rsp_paddr}, {12'd0, exp_pa});
    check({tag, " R8 req_ready low"}, {31'd0, req_ready}, 32'd0);
    check({tag, " R9 wr_ready low"}, {31'd0, wr_ready}, 32'd0);
    pa0 = rsp_paddr;
    repeat (2) @(negedge clk);
    check({tag, " R7 held valid"}, {31'd0, rsp_valid}, 32'd1);
    check({tag, " R7 held paddr"}, {12'd0, rsp_paddr}, {12'd0, pa0});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check({tag, " R7 retired"}, {31'd0, rsp_valid}, 32'd0);
    check({tag, " R8 ready again"}, {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_reset();
    check("R1 req_ready", {31'd0, req_ready}, 32'd1);
    check("R1 wr_ready", {31'd0, wr_ready}, 32'd1);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    xlate("R1 empty table", 8'h01, 20'h00001, 12'h123, 1'b1, 0, 1'b0);
  endtask

  task automatic t_basic();
    put_entry(7, 1'b1, 8'h04, 20'h12345);
    xlate("R3 basic", 8'h04, 20'h12345, 12'hABC, 1'b0, 7, 1'b0);
    put_entry(0, 1'b1, 8'h11, 20'h00010);
    xlate("R5 first entry", 8'h11, 20'h00010, 12'h001, 1'b0, 0, 1'b0);
    put_entry(255, 1'b1, 8'h02, 20'hFFFFF);
    xlate("R5 last entry", 8'h02, 20'hFFFFF, 12'hFFF, 1'b0, 255, 1'b0);
  endtask

  task automatic t_partial();
    put_entry(9, 1'b1, 8'h04, 20'h00777);
    xlate("R2 pid only differs", 8'h05, 20'h00777, 12'h010, 1'b1, 0, 1'b0);
    xlate("R2 vpn only differs", 8'h04, 20'h00778, 12'h010, 1'b1, 0, 1'b0);
    put_entry(20, 1'b0, 8'h06, 20'h00055);
    xlate("R2 invalid entry", 8'h06, 20'h00055, 12'h020, 1'b1, 0, 1'b0);
    xlate("R2 both match", 8'h04, 20'h00777, 12'h030, 1'b0, 9, 1'b0);
  endtask

  task automatic t_first();
    put_entry(40, 1'b1, 8'h08, 20'h00099);
    put_entry(30, 1'b1, 8'h08, 20'h00099);
    xlate("R4 lowest wins", 8'h08, 20'h00099, 12'h444, 1'b0, 30, 1'b0);
  endtask

  task automatic t_busy_write();
    @(negedge clk);
    req_valid = 1'b1; req_pid = 8'h33; req_vpn = 20'h03333; req_ofs = 12'h0;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 8'd5; wr_live = 1'b1; wr_pid = 8'h33; wr_vpn = 20'h03333;
    check("R9 wr_ready low in scan", {31'd0, wr_ready}, 32'd0);
    while (!rsp_valid) @(negedge clk);
    check("R9 held write unseen", {31'd0, rsp_fault}, 32'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R9 wr_ready back", {31'd0, wr_ready}, 32'd1);
    @(negedge clk);
    wr_en = 1'b0;
    xlate("R9 held write landed", 8'h33, 20'h03333, 12'h555, 1'b0, 5, 1'b0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 8'd3; wr_live = 1'b1; wr_pid = 8'h77; wr_vpn = 20'h0ABCD;
    xlate("R9 same-edge write", 8'h77, 20'h0ABCD, 12'h321, 1'b0, 3, 1'b1);
  endtask

  task automatic t_invalidate();
    put_entry(7, 1'b0, 8'h04, 20'h12345);
    xlate("R10 removed mapping", 8'h04, 20'h12345, 12'hABC, 1'b1, 0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_partial();
    t_first();
    t_busy_write();
    t_same_cycle();
    t_invalidate();
    finish_run();
  end
endmodule